// File: doc/BRIEF.md
# Card Status Change Event Register

This block keeps the event state that one card function reports to host software when it runs in CardBus mode. It records two kinds of event, a function interrupt and a general wake-up, in a 32-bit event word, and it keeps an enable word with the same bit layout. A status-change output goes high while any recorded event is also enabled. Software reads both words and writes ones to acknowledge events over a simple word-addressed register port. Byte enables on that port are accepted but have no effect.

The wake event is coupled to the power-management event status bit, which this block also holds. Acknowledging either one clears both. The interrupt event cannot be acknowledged until its source has been serviced. All of this state survives the ordinary function reset and is cleared only by the power-up reset. When the function runs as a plain PCI device the whole register window is closed.

Top module: `cbsc_event_regs`

## Requirements
- R1: Event bit 15 (interrupt) reads as 1 on the clock after `irq_src` is high, whatever the enable word holds.
- R2: A write to offset 0 with data bit 15 at 1 clears bit 15 only when `irq_serviced` is high in the write cycle. Otherwise the bit stays at 1.
- R3: Event bit 4 (wake) and `pme_status` both read as 1 on the clock after `wake_src` is high, whatever the enable word holds.
- R4: A write to offset 0 with data bit 4 at 1 clears both event bit 4 and `pme_status`.
- R5: A one-cycle pulse on `pme_clr_wr` (software writing 1 to the power-management event status bit) clears both `pme_status` and event bit 4.
- R6: Writing 0 to bit 15 or bit 4 leaves that bit unchanged. `reg_be` has no effect on any write.
- R7: Bits 31:16, 14:5 and 3:0 of the event word (offset 0) and of the enable word (offset 1) always read as 0.
- R8: When a set condition and an acknowledge of the same bit fall in the same cycle, the bit ends at 1.
- R9: While `por_n` is low, the event word, the enable word, `pme_status` and `csc_out` are all 0. A low pulse on `func_rst_n` changes none of them.
- R10: While `cardbus_mode` is 0, register writes change nothing and reads return 0.
- R11: `csc_out` is 1 exactly when some event bit is 1 and the enable-word bit at the same position (15 or 4) is 1. The enable word resets to 0.
- R12: `reg_rvalid` is high for one cycle, on the clock after `reg_rd`, with the data in `reg_rdata`. Offsets other than 0 and 1 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-up reset, active low; clears all event state |
| func_rst_n | input | 1 | Function reset, active low; clears only the read port |
| cardbus_mode | input | 1 | 1 opens the register window, 0 closes it (PCI mode) |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_addr | input | 4 | Word offset: 0 event word, 1 enable word |
| reg_wdata | input | 32 | Write data |
| reg_be | input | 4 | Byte enables, ignored |
| reg_rdata | output | 32 | Read data, one cycle after the strobe |
| reg_rvalid | output | 1 | Read data valid |
| irq_src | input | 1 | Function interrupt source |
| irq_serviced | input | 1 | Interrupt source has been serviced |
| wake_src | input | 1 | Wake-up source |
| pme_clr_wr | input | 1 | Write-1 pulse to the power-management event status bit |
| pme_status | output | 1 | Power-management event status |
| csc_out | output | 1 | Status-change output |

## Verification
The main stimulus is a sequence of source pulses and acknowledge writes. It combines each event with serviced and unserviced states, with all-zero, single-bit and all-ones write data, and with sets that coincide with acknowledges. This separates a clear that ignores the serviced qualifier from a correct one, a wake clear that leaves the power-management bit set from a coupled one, and a clear-wins priority from a set-wins priority. Directed cases then enable each event individually to tell a masked status output from an unmasked one. They also close the window in PCI mode, reach unmapped offsets and all-ones enable writes, and compare a function reset with a power-up reset.

// File: rtl/cbsc_pkg.sv
package cbsc_pkg;

   localparam int unsigned NUM_EVT = 2;

   typedef enum logic [0:0] {
      EVT_INTR = 1'b0,
      EVT_WAKE = 1'b1
   } evt_idx_e;

   typedef logic [NUM_EVT-1:0] evt_vec_t;

endpackage

// File: rtl/cbsc_flag.sv
module cbsc_flag #(
   parameter bit CLR_GATED = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   input  logic clr_ok_i,
   output logic q_o
);

   logic clr_eff;
   logic q_r;

   generate
      if (CLR_GATED) begin : g_gated
         assign clr_eff = clr_i & clr_ok_i;
      end else begin : g_plain
         logic unused_ok;
         assign unused_ok = clr_ok_i;
         assign clr_eff   = clr_i;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_r <= 1'b0;
      else        q_r <= set_i | (q_r & ~clr_eff);
   end

   assign q_o = q_r;

   a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> q_o);

   generate
      if (CLR_GATED) begin : g_chk_gated
         a_r2_hold_unserviced: assert property (@(posedge clk) disable iff (!rst_n)
            (q_o && !clr_ok_i) |=> q_o);
      end
   endgenerate

endmodule

// File: rtl/cbsc_mask_reg.sv
module cbsc_mask_reg #(
   parameter int unsigned WIDTH = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we_i,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("cbsc_mask_reg: WIDTH must be at least 1");
      end
   endgenerate

   logic [WIDTH-1:0] q_r;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q_r <= '0;
      else if (we_i) q_r <= d_i;
   end

   assign q_o = q_r;

   a_r11_mask_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !we_i |=> (q_o == $past(q_o)));

endmodule

// File: rtl/cbsc_rd_port.sv
module cbsc_rd_port
   import cbsc_pkg::*;
#(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned ADDR_W    = 4,
   parameter int unsigned EVT_OFFS  = 0,
   parameter int unsigned MASK_OFFS = 1,
   parameter int unsigned INTR_POS  = 15,
   parameter int unsigned WAKE_POS  = 4
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              func_rst_n,
   input  logic              rd_i,
   input  logic              en_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  evt_vec_t          flags_i,
   input  evt_vec_t          mask_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic              rvalid_o
);

   localparam logic [ADDR_W-1:0] EVT_A  = EVT_OFFS[ADDR_W-1:0];
   localparam logic [ADDR_W-1:0] MASK_A = MASK_OFFS[ADDR_W-1:0];

   logic              rst_n;
   logic [DATA_W-1:0] evt_word;
   logic [DATA_W-1:0] mask_word;
   logic [DATA_W-1:0] sel_word;

   assign rst_n = por_n & func_rst_n;

   always_comb begin
      evt_word            = '0;
      evt_word[INTR_POS]  = flags_i[EVT_INTR];
      evt_word[WAKE_POS]  = flags_i[EVT_WAKE];
      mask_word           = '0;
      mask_word[INTR_POS] = mask_i[EVT_INTR];
      mask_word[WAKE_POS] = mask_i[EVT_WAKE];
   end

   always_comb begin
      sel_word = '0;
      if (en_i) begin
         if (addr_i == EVT_A)       sel_word = evt_word;
         else if (addr_i == MASK_A) sel_word = mask_word;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata_o  <= '0;
         rvalid_o <= 1'b0;
      end else begin
         rvalid_o <= rd_i;
         if (rd_i) rdata_o <= sel_word;
      end
   end

   a_r12_rvalid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      rd_i |=> rvalid_o);
   a_r12_rvalid_single: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_i |=> !rvalid_o);
   a_r10_pci_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_i && !en_i) |=> (rdata_o == '0));

endmodule

// File: rtl/cbsc_event_regs.sv
module cbsc_event_regs
   import cbsc_pkg::*;
#(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned ADDR_W    = 4,
   parameter int unsigned EVT_OFFS  = 0,
   parameter int unsigned MASK_OFFS = 1,
   parameter int unsigned INTR_POS  = 15,
   parameter int unsigned WAKE_POS  = 4,
   parameter bit          CSC_REG   = 1'b0
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              func_rst_n,
   input  logic              cardbus_mode,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   input  logic [DATA_W/8-1:0] reg_be,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              reg_rvalid,
   input  logic              irq_src,
   input  logic              irq_serviced,
   input  logic              wake_src,
   input  logic              pme_clr_wr,
   output logic              pme_status,
   output logic              csc_out
);

   localparam logic [ADDR_W-1:0] EVT_A  = EVT_OFFS[ADDR_W-1:0];
   localparam logic [ADDR_W-1:0] MASK_A = MASK_OFFS[ADDR_W-1:0];

   generate
      if (DATA_W < 16 || DATA_W % 8 != 0) begin : g_bad_dw
         $error("cbsc_event_regs: DATA_W must be a multiple of 8, at least 16");
      end
      if (INTR_POS >= DATA_W || WAKE_POS >= DATA_W || INTR_POS == WAKE_POS) begin : g_bad_pos
         $error("cbsc_event_regs: event bit positions invalid");
      end
      if (EVT_OFFS == MASK_OFFS || EVT_OFFS >= (1 << ADDR_W) || MASK_OFFS >= (1 << ADDR_W)) begin : g_bad_offs
         $error("cbsc_event_regs: register offsets invalid");
      end
   endgenerate

   logic unused_bits;
   assign unused_bits = ^{reg_be, reg_wdata};

   logic     wr_evt, wr_mask;
   evt_vec_t set_vec, clr_vec, ok_vec, flags, mask, mask_d, pend;

   assign wr_evt  = reg_wr & cardbus_mode & (reg_addr == EVT_A);
   assign wr_mask = reg_wr & cardbus_mode & (reg_addr == MASK_A);

   assign set_vec[EVT_INTR] = irq_src;
   assign set_vec[EVT_WAKE] = wake_src;
   assign clr_vec[EVT_INTR] = wr_evt & reg_wdata[INTR_POS];
   assign clr_vec[EVT_WAKE] = (wr_evt & reg_wdata[WAKE_POS]) | pme_clr_wr;
   assign ok_vec[EVT_INTR]  = irq_serviced;
   assign ok_vec[EVT_WAKE]  = 1'b1;
   assign mask_d[EVT_INTR]  = reg_wdata[INTR_POS];
   assign mask_d[EVT_WAKE]  = reg_wdata[WAKE_POS];

   generate
      for (genvar i = 0; i < NUM_EVT; i++) begin : g_evt
         cbsc_flag #(.CLR_GATED(i == EVT_INTR)) u_flag (
            .clk     (clk),
            .rst_n   (por_n),
            .set_i   (set_vec[i]),
            .clr_i   (clr_vec[i]),
            .clr_ok_i(ok_vec[i]),
            .q_o     (flags[i])
         );
      end
   endgenerate

   cbsc_flag #(.CLR_GATED(1'b0)) u_pme (
      .clk     (clk),
      .rst_n   (por_n),
      .set_i   (wake_src),
      .clr_i   (clr_vec[EVT_WAKE]),
      .clr_ok_i(1'b1),
      .q_o     (pme_status)
   );

   cbsc_mask_reg #(.WIDTH(NUM_EVT)) u_mask (
      .clk  (clk),
      .rst_n(por_n),
      .we_i (wr_mask),
      .d_i  (mask_d),
      .q_o  (mask)
   );

   cbsc_rd_port #(
      .DATA_W   (DATA_W),
      .ADDR_W   (ADDR_W),
      .EVT_OFFS (EVT_OFFS),
      .MASK_OFFS(MASK_OFFS),
      .INTR_POS (INTR_POS),
      .WAKE_POS (WAKE_POS)
   ) u_rd (
      .clk       (clk),
      .por_n     (por_n),
      .func_rst_n(func_rst_n),
      .rd_i      (reg_rd),
      .en_i      (cardbus_mode),
      .addr_i    (reg_addr),
      .flags_i   (flags),
      .mask_i    (mask),
      .rdata_o   (reg_rdata),
      .rvalid_o  (reg_rvalid)
   );

   assign pend = flags & mask;

   generate
      if (CSC_REG) begin : g_csc_reg
         logic csc_r;
         always_ff @(posedge clk or negedge por_n) begin
            if (!por_n) csc_r <= 1'b0;
            else        csc_r <= |pend;
         end
         assign csc_out = csc_r;
      end else begin : g_csc_comb
         assign csc_out = |pend;
      end
   endgenerate

   a_r1_intr_sets: assert property (@(posedge clk) disable iff (!por_n)
      irq_src |=> flags[EVT_INTR]);
   a_r3_wake_and_pme_set: assert property (@(posedge clk) disable iff (!por_n)
      wake_src |=> (flags[EVT_WAKE] && pme_status));
   a_r4_wake_pme_clear_together: assert property (@(posedge clk) disable iff (!por_n)
      (clr_vec[EVT_WAKE] && !wake_src) |=> (!flags[EVT_WAKE] && !pme_status));
   a_r10_pci_write_ignored: assert property (@(posedge clk) disable iff (!por_n)
      (reg_wr && !cardbus_mode && !irq_src && !wake_src && !pme_clr_wr)
      |=> (flags == $past(flags) && mask == $past(mask)));
   a_r11_csc_idle_when_masked: assert property (@(posedge clk) disable iff (!por_n)
      (mask == '0 && !CSC_REG) |-> !csc_out);

endmodule

// File: tb/cbsc_event_regs_bench.sv
module cbsc_event_regs_bench;

   logic        clk = 1'b0;
   logic        por_n, func_rst_n, cardbus_mode;
   logic        reg_wr, reg_rd;
   logic [3:0]  reg_addr;
   logic [31:0] reg_wdata;
   logic [3:0]  reg_be;
   logic [31:0] reg_rdata;
   logic        reg_rvalid;
   logic        irq_src, irq_serviced, wake_src, pme_clr_wr;
   logic        pme_status, csc_out;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;

   always #4 clk = ~clk;

   cbsc_event_regs u_cbsc_event_regs (
      .clk(clk), .por_n(por_n), .func_rst_n(func_rst_n), .cardbus_mode(cardbus_mode),
      .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_be(reg_be), .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid),
      .irq_src(irq_src), .irq_serviced(irq_serviced), .wake_src(wake_src),
      .pme_clr_wr(pme_clr_wr), .pme_status(pme_status), .csc_out(csc_out)
   );

   typedef struct packed {
      logic        irq;
      logic        serv;
      logic        wake;
      logic        wr;
      logic [31:0] wdata;
      logic [31:0] exp_evt;
      logic        exp_pme;
   } vec_t;

   localparam int NVEC = 12;
   localparam vec_t VEC [NVEC] = '{
      '{1'b1, 1'b0, 1'b0, 1'b0, 32'h0000_0000, 32'h0000_8000, 1'b0}, // R1
      '{1'b0, 1'b0, 1'b0, 1'b1, 32'h0000_8000, 32'h0000_8000, 1'b0}, // R2 unserviced
      '{1'b0, 1'b1, 1'b0, 1'b1, 32'h0000_8000, 32'h0000_0000, 1'b0}, // R2 serviced
      '{1'b0, 1'b0, 1'b1, 1'b0, 32'h0000_0000, 32'h0000_0010, 1'b1}, // R3
      '{1'b0, 1'b0, 1'b0, 1'b1, 32'h0000_0000, 32'h0000_0010, 1'b1}, // R6
      '{1'b0, 1'b0, 1'b0, 1'b1, 32'h0000_0010, 32'h0000_0000, 1'b0}, // R4
      '{1'b1, 1'b0, 1'b1, 1'b0, 32'h0000_0000, 32'h0000_8010, 1'b1}, // R1 R3
      '{1'b0, 1'b1, 1'b0, 1'b1, 32'hFFFF_FFFF, 32'h0000_0000, 1'b0}, // R2 R4
      '{1'b1, 1'b1, 1'b0, 1'b1, 32'h0000_8000, 32'h0000_8000, 1'b0}, // R8
      '{1'b0, 1'b1, 1'b0, 1'b1, 32'h0000_8000, 32'h0000_0000, 1'b0}, // R2
      '{1'b0, 1'b0, 1'b1, 1'b1, 32'h0000_0010, 32'h0000_0010, 1'b1}, // R8
      '{1'b0, 1'b0, 1'b0, 1'b1, 32'h0000_0010, 32'h0000_0000, 1'b0}  // R4
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr_reg(input logic [3:0] a, input logic [31:0] d, input logic [3:0] be);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d; reg_be = be;
      @(posedge clk);
      @(negedge clk);
      reg_wr = 1'b0; reg_wdata = '0;
   endtask

   task automatic rd_reg(input logic [3:0] a, output logic [31:0] d, output logic v);
      @(negedge clk);
      reg_rd = 1'b1; reg_addr = a;
      @(posedge clk);
      @(negedge clk);
      reg_rd = 1'b0;
      d = reg_rdata; v = reg_rvalid;
   endtask

   task automatic pulse_src(input logic irq, input logic wake);
      @(negedge clk);
      irq_src = irq; wake_src = wake;
      @(posedge clk);
      @(negedge clk);
      irq_src = 1'b0; wake_src = 1'b0;
   endtask

   task automatic finish_run;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 20000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected<=20000", cycles);
            finish_run();
         end
      end
   end

   initial begin
      logic [31:0] d;
      logic        v;
      por_n = 1'b0; func_rst_n = 1'b0; cardbus_mode = 1'b1;
      reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = '0; reg_wdata = '0; reg_be = 4'hF;
      irq_src = 1'b0; irq_serviced = 1'b0; wake_src = 1'b0; pme_clr_wr = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R9 pme in reset", {31'b0, pme_status}, 32'h0);
      check("R9 csc in reset", {31'b0, csc_out}, 32'h0);
      por_n = 1'b1; func_rst_n = 1'b1;

      rd_reg(4'd0, d, v);
      check("R9 event word after reset", d, 32'h0);
      check("R12 rvalid", {31'b0, v}, 32'h1);
      rd_reg(4'd1, d, v);
      check("R11 mask resets to zero", d, 32'h0);

      for (int i = 0; i < NVEC; i++) begin
         @(negedge clk);
         irq_src = VEC[i].irq; irq_serviced = VEC[i].serv; wake_src = VEC[i].wake;
         reg_wr = VEC[i].wr; reg_addr = 4'd0; reg_wdata = VEC[i].wdata;
         @(posedge clk);
         @(negedge clk);
         irq_src = 1'b0; irq_serviced = 1'b0; wake_src = 1'b0; reg_wr = 1'b0;
         check($sformatf("R1-vec%0d csc stays low with mask zero (R1 R3 R11)", i),
               {31'b0, csc_out}, 32'h0);
         rd_reg(4'd0, d, v);
         check($sformatf("vec%0d event word (R1 R2 R3 R4 R6 R8)", i), d, VEC[i].exp_evt);
         check($sformatf("vec%0d pme_status (R3 R4)", i), {31'b0, pme_status},
               {31'b0, VEC[i].exp_pme});
      end

      // R5: power-management write clears wake flag and pme
      pulse_src(1'b0, 1'b1);
      @(negedge clk); pme_clr_wr = 1'b1;
      @(posedge clk); @(negedge clk); pme_clr_wr = 1'b0;
      rd_reg(4'd0, d, v);
      check("R5 wake cleared by pme write", d, 32'h0);
      check("R5 pme cleared", {31'b0, pme_status}, 32'h0);

      // R7 and R11: enable word
      wr_reg(4'd1, 32'hFFFF_FFFF, 4'hF);
      rd_reg(4'd1, d, v);
      check("R7 enable word reserved bits zero", d, 32'h0000_8010);
      wr_reg(4'd1, 32'h0000_8000, 4'hF);
      pulse_src(1'b0, 1'b1);
      check("R11 wake not enabled", {31'b0, csc_out}, 32'h0);
      pulse_src(1'b1, 1'b0);
      check("R11 intr enabled raises csc", {31'b0, csc_out}, 32'h1);
      wr_reg(4'd1, 32'h0000_0010, 4'hF);
      check("R11 wake enabled raises csc", {31'b0, csc_out}, 32'h1);
      wr_reg(4'd1, 32'h0, 4'hF);
      check("R11 csc drops with mask cleared", {31'b0, csc_out}, 32'h0);

      // R10: PCI mode closes the window
      cardbus_mode = 1'b0;
      rd_reg(4'd0, d, v);
      check("R10 pci read returns zero", d, 32'h0);
      irq_serviced = 1'b1;
      wr_reg(4'd0, 32'hFFFF_FFFF, 4'hF);
      wr_reg(4'd1, 32'hFFFF_FFFF, 4'hF);
      irq_serviced = 1'b0;
      check("R10 pci write left pme", {31'b0, pme_status}, 32'h1);
      cardbus_mode = 1'b1;
      rd_reg(4'd0, d, v);
      check("R10 pci write left flags", d, 32'h0000_8010);
      rd_reg(4'd1, d, v);
      check("R10 pci write left mask", d, 32'h0);

      // R12: unmapped offset
      rd_reg(4'd2, d, v);
      check("R12 unmapped offset reads zero", d, 32'h0);
      @(negedge clk);
      check("R12 rvalid single cycle", {31'b0, reg_rvalid}, 32'h0);

      // R6: byte enables ignored
      irq_serviced = 1'b1;
      wr_reg(4'd0, 32'h0000_8000, 4'h0);
      irq_serviced = 1'b0;
      rd_reg(4'd0, d, v);
      check("R6 write with be=0 still clears", d, 32'h0000_0010);

      // R9: function reset keeps state, power-up reset clears it
      wr_reg(4'd1, 32'h0000_0010, 4'hF);
      @(negedge clk); func_rst_n = 1'b0;
      @(posedge clk); @(negedge clk); func_rst_n = 1'b1;
      rd_reg(4'd0, d, v);
      check("R9 function reset keeps flags", d, 32'h0000_0010);
      rd_reg(4'd1, d, v);
      check("R9 function reset keeps mask", d, 32'h0000_0010);
      check("R9 function reset keeps csc", {31'b0, csc_out}, 32'h1);
      @(negedge clk); por_n = 1'b0;
      @(posedge clk); @(negedge clk);
      check("R9 por clears csc", {31'b0, csc_out}, 32'h0);
      check("R9 por clears pme", {31'b0, pme_status}, 32'h0);
      por_n = 1'b1;
      rd_reg(4'd0, d, v);
      check("R9 por clears flags", d, 32'h0);
      rd_reg(4'd1, d, v);
      check("R9 por clears mask", d, 32'h0);

      finish_run();
   end

endmodule